// File: doc/BRIEF.md
# Timer Clock Front End with Cross-Domain Register Bridge

This block sits in front of an 8-bit timer and supplies both its clock and its rate. A source-select input chooses whether the timer domain runs from the bus clock or from a separate slow clock, such as a watch-crystal oscillator. A 10-bit prescale counter in that domain turns the chosen clock into a one-cycle tick enable. The ratio comes from a 3-bit field in the timer's control register. The downstream timer advances on this tick.

The timer's count, compare and control registers live in the timer domain, but software writes them from the bus domain. Each register has its own channel. A channel holds the written value in a bus-side holding register and signals the timer side by toggling a request bit. The timer side captures the value and toggles an acknowledge bit, which returns to the bus side through a synchronizer. While a channel is in flight its busy bit reads 1. A write to a busy channel is discarded and sets a sticky error flag. Writes to the count register reach the timer as a one-cycle load strobe; the compare and control values are held.

Top module: `tcb_clock_bridge`

## Requirements
- R1: The low three control-register bits (`tmr_ctrl[2:0]`) select the tick ratio: 001 gives /1, 010 /8, 011 /32, 100 /64, 101 /128, 110 /256 and 111 /1024. `tmr_tick` is high for one timer-clock cycle in every N, and at /1 it is high in every cycle.
- R2: With a select value of 000 the prescaler is stopped and `tmr_tick` stays low.
- R3: The prescale counter is 10 bits wide, so the /1024 ratio produces one tick every 1024 timer-clock cycles.
- R4: With `use_slow` = 0 the timer domain (`tmr_clk`) follows `bus_clk`. With `use_slow` = 1 it follows `slow_clk`, and tick periods are counted in `slow_clk` cycles.
- R5: A write accepted on a channel sets that channel's busy bit on the next bus edge. The bit clears only after the timer side has captured the value and its acknowledge has crossed two synchronizer flops. When both sides share `bus_clk`, busy is high for exactly five cycles after the write edge.
- R6: A captured value becomes visible in the timer domain on the third timer edge after the write edge, when both sides share `bus_clk`. A count write produces exactly one `tmr_cnt_ld` pulse carrying the value. Compare and control values hold until the next accepted write.
- R7: A write to a channel whose busy bit is 1 is dropped and sets `wr_err`. `wr_err` stays set until `err_clr` is asserted.
- R8: The prescale counter restarts from zero when a newly captured control value changes the select field, and when the source selection changes. After such a restart, the first tick at ratio N comes N-1 timer cycles after the capture edge.
- R9: After reset, all busy bits and `wr_err` are 0, the compare and control registers are 0, and no ticks are produced.
- R10: `wr_sel` selects the channel: 0 = count, 1 = compare, 2 = control. The value 3 writes nothing and sets no busy or error bit.
- R11: The channels are independent: a busy channel does not block a write to another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst | input | 1 | Synchronous active-high reset in the bus domain; a synchronized copy resets the timer domain |
| slow_clk | input | 1 | Separate slow clock source |
| use_slow | input | 1 | Source select for the timer domain: 0 = bus clock, 1 = slow clock |
| wr_en | input | 1 | Register write strobe (bus domain) |
| wr_sel | input | 2 | Target register: 0 count, 1 compare, 2 control, 3 none |
| wr_data | input | 8 | Write value |
| err_clr | input | 1 | Clears the sticky write error flag |
| busy | output | 3 | Per-channel update-busy bits: [0] count, [1] compare, [2] control |
| wr_err | output | 1 | Sticky flag: a write hit a busy channel |
| tmr_clk | output | 1 | Selected timer-domain clock |
| tmr_tick | output | 1 | One-cycle prescaled tick enable (timer domain) |
| tmr_cnt_ld | output | 1 | One-cycle count load strobe (timer domain) |
| tmr_cnt_val | output | 8 | Value to load into the count register with `tmr_cnt_ld` |
| tmr_cmp | output | 8 | Compare register (timer domain) |
| tmr_ctrl | output | 8 | Control register (timer domain); bits [2:0] select the ratio |

## Verification
The bench builds the block with its defaults: a 10-bit prescaler and two-flop synchronizers. With these settings every ratio up to /1024 can be measured in a few thousand cycles, and the five-cycle busy window, the third-edge capture and the restart latency each come out as exact cycle counts in the shared-clock case. A second phase switches to a slow clock five times slower than the bus clock. In that phase the handshake is completed by polling busy, and tick spacing is checked in bus cycles (eight slow cycles, or forty bus cycles).

// File: rtl/tcb_pkg.sv
package tcb_pkg;

    localparam int REG_W  = 8;
    localparam int CS_W   = 3;
    localparam int NUM_CH = 3;

    typedef enum logic [1:0] {
        SEL_COUNT = 2'd0,
        SEL_CMP   = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef enum logic [CS_W-1:0] {
        CS_OFF   = 3'd0,
        CS_D1    = 3'd1,
        CS_D8    = 3'd2,
        CS_D32   = 3'd3,
        CS_D64   = 3'd4,
        CS_D128  = 3'd5,
        CS_D256  = 3'd6,
        CS_D1024 = 3'd7
    } clk_sel_e;

    typedef struct packed {
        logic              en;
        reg_sel_e          sel;
        logic [REG_W-1:0]  data;
    } bus_wr_t;

    // log2 of the division ratio for each select code
    function automatic int div_shift(clk_sel_e s);
        case (s)
            CS_D8:    return 3;
            CS_D32:   return 5;
            CS_D64:   return 6;
            CS_D128:  return 7;
            CS_D256:  return 8;
            CS_D1024: return 10;
            default:  return 0;
        endcase
    endfunction

endpackage

// File: rtl/tcb_sync.sv
module tcb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= {sr_q[STAGES-2:0], d};
    end

    assign q = sr_q[STAGES-1];

    initial begin
        assert (STAGES >= 2) else $error("synchronizer needs at least two stages");
    end
endmodule

// File: rtl/tcb_chan.sv
module tcb_chan
    import tcb_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst,
    input  logic             wr_go,
    input  logic [REG_W-1:0] wr_data,
    output logic             busy_o,
    input  logic             tmr_clk,
    input  logic             tmr_rst,
    output logic             cap_o,
    output logic [REG_W-1:0] cap_data_o
);
    logic             req_q;
    logic [REG_W-1:0] hold_q;
    logic             ack_s;
    logic             req_s;
    logic             ack_t_q;
    logic             accept;

    // bus side: toggle request and hold the data
    assign accept = wr_go && !busy_o;

    always_ff @(posedge bus_clk) begin
        if (bus_rst) begin
            req_q  <= 1'b0;
            hold_q <= '0;
        end else if (accept) begin
            req_q  <= ~req_q;
            hold_q <= wr_data;
        end
    end

    tcb_sync #(.STAGES(SYNC_N)) u_ack_sync (
        .clk (bus_clk),
        .rst (bus_rst),
        .d   (ack_t_q),
        .q   (ack_s)
    );

    assign busy_o = req_q ^ ack_s;

    // timer side: detect request toggle, answer with acknowledge toggle
    tcb_sync #(.STAGES(SYNC_N)) u_req_sync (
        .clk (tmr_clk),
        .rst (tmr_rst),
        .d   (req_q),
        .q   (req_s)
    );

    always_ff @(posedge tmr_clk) begin
        if (tmr_rst) ack_t_q <= 1'b0;
        else         ack_t_q <= req_s;
    end

    assign cap_o      = req_s ^ ack_t_q;
    assign cap_data_o = hold_q;

    assert_busy_on_accept_R5: assert property (@(posedge bus_clk) disable iff (bus_rst)
        accept |=> busy_o);

    assert_hold_stable_R5: assert property (@(posedge bus_clk) disable iff (bus_rst)
        busy_o |=> $stable(hold_q));

    assert_cap_single_R6: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
        cap_o |=> !cap_o);
endmodule

// File: rtl/tcb_prescaler.sv
module tcb_prescaler
    import tcb_pkg::*;
#(
    parameter int PRE_W = 10
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_sel_e sel,
    input  logic     restart,
    output logic     tick
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W:0]   one_hot;
    logic [PRE_W-1:0] mask;
    logic             running;

    assign running = (sel != CS_OFF);
    assign one_hot = (PRE_W+1)'(1) << div_shift(sel);
    assign mask    = PRE_W'(one_hot - (PRE_W+1)'(1));
    assign tick    = running && ((cnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || restart || !running) cnt_q <= '0;
        else                            cnt_q <= cnt_q + 1'b1;
    end

    initial begin
        assert (PRE_W >= 10) else $error("prescaler too narrow for /1024");
    end

    assert_restart_zero_R8: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0));

    assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && sel != CS_D1 && !restart) |=> (!tick || sel != $past(sel)));
endmodule

// File: rtl/tcb_clock_bridge.sv
module tcb_clock_bridge
    import tcb_pkg::*;
#(
    parameter int PRE_W  = 10,
    parameter int SYNC_N = 2
) (
    input  logic             bus_clk,
    input  logic             bus_rst,
    input  logic             slow_clk,
    input  logic             use_slow,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             err_clr,
    output logic [NUM_CH-1:0] busy,
    output logic             wr_err,
    output logic             tmr_clk,
    output logic             tmr_tick,
    output logic             tmr_cnt_ld,
    output logic [REG_W-1:0] tmr_cnt_val,
    output logic [REG_W-1:0] tmr_cmp,
    output logic [REG_W-1:0] tmr_ctrl
);
    bus_wr_t          wr;
    logic [NUM_CH-1:0] go;
    logic [NUM_CH-1:0] cap;
    logic [REG_W-1:0]  cap_data [NUM_CH];
    logic [SYNC_N-1:0] trst_sr;
    logic              tmr_rst;
    logic              slow_s;
    logic              slow_prev_q;
    logic              restart;
    logic              hit_busy;
    logic [REG_W-1:0]  cmp_q;
    logic [REG_W-1:0]  ctrl_q;
    clk_sel_e          cur_sel;
    clk_sel_e          new_sel;

    // timer-domain clock source
    assign tmr_clk = use_slow ? slow_clk : bus_clk;

    // reset carried into the timer domain
    always_ff @(posedge tmr_clk) trst_sr <= {trst_sr[SYNC_N-2:0], bus_rst};
    assign tmr_rst = trst_sr[SYNC_N-1];

    assign wr = '{en: wr_en, sel: reg_sel_e'(wr_sel), data: wr_data};

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign go[c] = wr.en && (wr.sel == reg_sel_e'(c));
            tcb_chan #(.SYNC_N(SYNC_N)) u_chan (
                .bus_clk    (bus_clk),
                .bus_rst    (bus_rst),
                .wr_go      (go[c]),
                .wr_data    (wr.data),
                .busy_o     (busy[c]),
                .tmr_clk    (tmr_clk),
                .tmr_rst    (tmr_rst),
                .cap_o      (cap[c]),
                .cap_data_o (cap_data[c])
            );
        end
    endgenerate

    // sticky error for writes that hit a busy channel
    assign hit_busy = |(go & busy);

    always_ff @(posedge bus_clk) begin
        if (bus_rst)       wr_err <= 1'b0;
        else if (hit_busy) wr_err <= 1'b1;
        else if (err_clr)  wr_err <= 1'b0;
    end

    // timer-domain registers
    always_ff @(posedge tmr_clk) begin
        if (tmr_rst) begin
            cmp_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (cap[SEL_CMP])  cmp_q  <= cap_data[SEL_CMP];
            if (cap[SEL_CTRL]) ctrl_q <= cap_data[SEL_CTRL];
        end
    end

    tcb_sync #(.STAGES(SYNC_N)) u_src_sync (
        .clk (tmr_clk),
        .rst (tmr_rst),
        .d   (use_slow),
        .q   (slow_s)
    );

    always_ff @(posedge tmr_clk) begin
        if (tmr_rst) slow_prev_q <= 1'b0;
        else         slow_prev_q <= slow_s;
    end

    assign cur_sel = clk_sel_e'(ctrl_q[CS_W-1:0]);
    assign new_sel = clk_sel_e'(cap_data[SEL_CTRL][CS_W-1:0]);
    assign restart = (cap[SEL_CTRL] && new_sel != cur_sel) || (slow_s != slow_prev_q);

    tcb_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (tmr_clk),
        .rst     (tmr_rst),
        .sel     (cur_sel),
        .restart (restart),
        .tick    (tmr_tick)
    );

    assign tmr_cnt_ld  = cap[SEL_COUNT];
    assign tmr_cnt_val = cap_data[SEL_COUNT];
    assign tmr_cmp     = cmp_q;
    assign tmr_ctrl    = ctrl_q;

    assert_drop_err_R7: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (wr_en && wr_sel != SEL_NONE && busy[wr_sel]) |=> wr_err);

    assert_none_sel_idle_R10: assert property (@(posedge bus_clk) disable iff (bus_rst)
        (wr_en && wr_sel == SEL_NONE && busy == '0) |=> (busy == '0));

    assert_stop_no_tick_R2: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
        (ctrl_q[CS_W-1:0] == CS_OFF) |-> !tmr_tick);

    assert_ctrl_hold_R6: assert property (@(posedge tmr_clk) disable iff (tmr_rst)
        !cap[SEL_CTRL] |=> $stable(ctrl_q));
endmodule

// File: tb/tcb_clock_bridge_bench.sv
`timescale 1ns/1ps
module tcb_clock_bridge_bench;

    logic       bus_clk = 1'b0;
    logic       slow_clk = 1'b0;
    logic       bus_rst = 1'b1;
    logic       use_slow = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       err_clr = 1'b0;
    logic [2:0] busy;
    logic       wr_err;
    logic       tmr_clk;
    logic       tmr_tick;
    logic       tmr_cnt_ld;
    logic [7:0] tmr_cnt_val;
    logic [7:0] tmr_cmp;
    logic [7:0] tmr_ctrl;

    int n_checks = 0;
    int n_fail   = 0;
    int ld_n     = 0;
    logic [7:0] ld_v = 8'd0;

    always #2.5  bus_clk  = ~bus_clk;
    always #12.5 slow_clk = ~slow_clk;

    tcb_clock_bridge u_tcb_clock_bridge (
        .bus_clk, .bus_rst, .slow_clk, .use_slow, .wr_en, .wr_sel, .wr_data,
        .err_clr, .busy, .wr_err, .tmr_clk, .tmr_tick, .tmr_cnt_ld,
        .tmr_cnt_val, .tmr_cmp, .tmr_ctrl
    );

    localparam int NV = 7;
    localparam logic [2:0] VEC_CS  [NV] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    localparam int         VEC_DIV [NV] = '{1, 8, 32, 64, 128, 256, 1024};

    always @(negedge tmr_clk) begin
        if (!bus_rst && tmr_cnt_ld) begin
            ld_n++;
            ld_v = tmr_cnt_val;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // returns at the negedge after the write edge
    task automatic do_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 4000; k++) begin
            if (busy == 3'b000) break;
            @(negedge bus_clk);
        end
    endtask

    // timer-clock cycles between two consecutive ticks
    task automatic tick_period(output int per);
        per = -1;
        for (int k = 0; k < 3000; k++) begin
            @(negedge tmr_clk);
            if (tmr_tick) break;
        end
        for (int k = 1; k < 3000; k++) begin
            @(negedge tmr_clk);
            if (tmr_tick) begin per = k; break; end
        end
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int per;
        int first;
        int ticks;
        int ld0;
        int rises;
        int gap;
        logic prev;

        repeat (6) @(negedge bus_clk);
        bus_rst = 1'b0;
        repeat (6) @(negedge bus_clk);

        // R9 reset state
        check(busy == 3'b000, "R9 busy", busy, 0);
        check(wr_err == 1'b0, "R9 err", wr_err, 0);
        check(tmr_ctrl == 8'd0 && tmr_cmp == 8'd0, "R9 regs", tmr_ctrl, 0);
        ticks = 0;
        repeat (20) begin @(negedge bus_clk); if (tmr_tick) ticks++; end
        check(ticks == 0, "R9 no tick", ticks, 0);

        // R5/R6 exact handshake timing on a shared clock
        do_write(2'd1, 8'h5A);
        for (int i = 0; i < 6; i++) begin
            if (i == 0 || i == 4) check(busy[1] == 1'b1, "R5 busy high", busy[1], 1);
            if (i == 2) check(tmr_cmp == 8'h00, "R6 not yet captured", tmr_cmp, 0);
            if (i == 3) check(tmr_cmp == 8'h5A, "R6 captured", tmr_cmp, 'h5A);
            if (i == 5) check(busy[1] == 1'b0, "R5 busy cleared", busy[1], 0);
            @(negedge bus_clk);
        end

        // R1 and R3: ratio table walked in one loop
        for (int v = 0; v < NV; v++) begin
            do_write(2'd2, {5'd0, VEC_CS[v]});
            wait_idle();
            tick_period(per);
            check(per == VEC_DIV[v], "R1 tick period", per, VEC_DIV[v]);
            if (VEC_DIV[v] == 1024) check(per == 1024, "R3 ten-bit wrap", per, 1024);
        end

        // R2 stopped prescaler
        do_write(2'd2, 8'd0);
        wait_idle();
        ticks = 0;
        repeat (2100) begin @(negedge bus_clk); if (tmr_tick) ticks++; end
        check(ticks == 0, "R2 stopped", ticks, 0);

        // R8 restart on select change: /8 running, then /64
        do_write(2'd2, 8'd2);
        wait_idle();
        repeat (3) @(negedge bus_clk);
        do_write(2'd2, 8'd4);
        first = -1;
        for (int i = 0; i < 200; i++) begin
            if (i >= 3 && tmr_tick) begin first = i; break; end
            @(negedge bus_clk);
        end
        check(first == 66, "R8 restart /64", first, 66);
        wait_idle();
        do_write(2'd2, 8'd1);
        first = -1;
        for (int i = 0; i < 50; i++) begin
            if (i >= 3 && tmr_tick) begin first = i; break; end
            @(negedge bus_clk);
        end
        check(first == 3, "R8 restart /1", first, 3);
        wait_idle();

        // R11 independent channels, then R7 dropped write
        do_write(2'd2, 8'd2);
        do_write(2'd1, 8'h33);
        check(wr_err == 1'b0, "R11 no error", wr_err, 0);
        check(busy[1] == 1'b1 && busy[2] == 1'b1, "R11 both busy", busy, 6);
        wait_idle();
        check(tmr_cmp == 8'h33, "R11 compare taken", tmr_cmp, 'h33);
        do_write(2'd2, 8'd5);
        do_write(2'd2, 8'd7);
        check(wr_err == 1'b1, "R7 error set", wr_err, 1);
        wait_idle();
        repeat (10) @(negedge bus_clk);
        check(tmr_ctrl == 8'd5, "R7 write dropped", tmr_ctrl, 5);
        repeat (3) @(negedge bus_clk);
        check(wr_err == 1'b1, "R7 sticky", wr_err, 1);
        err_clr = 1'b1;
        @(negedge bus_clk);
        err_clr = 1'b0;
        check(wr_err == 1'b0, "R7 cleared", wr_err, 0);

        // R10 unused select
        do_write(2'd3, 8'hFF);
        check(busy == 3'b000 && wr_err == 1'b0, "R10 none select", busy, 0);
        repeat (10) @(negedge bus_clk);
        check(tmr_ctrl == 8'd5 && tmr_cmp == 8'h33, "R10 regs untouched", tmr_ctrl, 5);

        // R6 count load strobe
        ld0 = ld_n;
        do_write(2'd0, 8'hFC);
        wait_idle();
        repeat (5) @(negedge bus_clk);
        check(ld_n - ld0 == 1, "R6 one load", ld_n - ld0, 1);
        check(ld_v == 8'hFC, "R6 load value", ld_v, 'hFC);

        // R4 slow clock source, /8 measured in bus cycles
        @(negedge bus_clk);
        use_slow = 1'b1;
        repeat (40) @(negedge bus_clk);
        do_write(2'd2, 8'd2);
        wait_idle();
        check(tmr_ctrl == 8'd2, "R4 slow-domain capture", tmr_ctrl, 2);
        ld0 = ld_n;
        do_write(2'd0, 8'h11);
        wait_idle();
        repeat (20) @(negedge bus_clk);
        check(ld_n - ld0 == 1 && ld_v == 8'h11, "R4 slow load", ld_v, 'h11);
        rises = 0; gap = -1; per = 0; prev = tmr_tick;
        for (int k = 0; k < 400; k++) begin
            @(negedge bus_clk);
            per++;
            if (tmr_tick && !prev) begin
                rises++;
                if (rises == 2) gap = per;
                per = 0;
            end
            prev = tmr_tick;
            if (rises == 2) break;
        end
        check(gap == 40, "R4 slow tick spacing", gap, 40);

        summary();
        $finish;
    end
endmodule